// File: doc/BRIEF.md
# Byte-Counted SPI Master with Word FIFOs

This block is a serial peripheral master that moves a programmed number of bytes between two word-wide queues and a four-wire serial link. The host fills the transmit queue with 32-bit words, loads a byte count and a clock divider, and then sets a run flag. Bytes are pulled from each queued word lowest byte first and shifted out most significant bit first. The bytes that come back are packed into words for the receive queue. Clocking waits until the transmit queue holds data. When the byte count is spent, the run flag drops by itself.

A transfer does not have to use a whole word. Bytes it does not consume stay at the head of the transmit queue, and the next transfer takes them first unless the host flushes the queue. In the optional framing mode, chip enable rises after every pair of bytes. A peripheral that expects 16-bit frames therefore gets one select pulse per frame. A two-bit select field picks which of the two chip-enable lines is used. Threshold-driven request outputs tell the host when the transmit queue needs refilling and when the receive queue should be drained.

Top module: `spi_len_master`

## Requirements
- R1: After reset, xfer_active is 0, sclk is 0, both ce_n lines are 1, both queues are empty, tx_req is 1 and rx_req is 0 (the threshold register resets to 8 for both sides).
- R2: A write to cfg_addr 0 with bit 4 set, made while idle, sets xfer_active. No sclk edge occurs while the transmit queue is empty. The transfer proceeds as soon as a word is pushed.
- R3: cfg_addr 1 holds a byte count. Each completed byte decrements it. xfer_active clears by itself on the cycle after the count reaches 0. Starting with a count of 0 produces no sclk edge. sclk is low whenever xfer_active falls.
- R4: While xfer_active is 1, writes to cfg_addr 1 (length), to cfg_addr 2 (divider), and to bits 1:0, 4 and 5 of cfg_addr 0 have no effect.
- R5: Bytes leave a transmit word in the order bits 7:0, 15:8, 23:16, 31:24. Each byte is sent MSB first. mosi changes only while sclk is low, and miso is sampled on the rising sclk edge.
- R6: Bytes of a transmit word that a transfer does not consume remain queued, and the next transfer sends them first.
- R7: Received bytes fill a word starting at bits 7:0. A word is pushed when its four bytes are complete, or when the last byte of the count arrives; in the second case the unfilled upper bytes read 0.
- R8: With bit 5 of cfg_addr 0 set, the selected chip enable goes low before each group of two bytes, and before a final odd byte, and high after it. With bit 5 clear, it stays low for as long as xfer_active is 1. When idle, both ce_n lines are high.
- R9: Bits 1:0 of cfg_addr 0 select the line: value 0 drives ce_n[0], value 1 drives ce_n[1], and values 2 and 3 drive neither. At most one line is ever low.
- R10: sclk stays high for N system clocks and low for N system clocks, where N is the value in cfg_addr 2. A value of 0 acts as 65536.
- R11: Bit 2 (transmit) and bit 3 (receive) of a cfg_addr 0 write each empty their queue in one cycle. Clearing the transmit queue also discards any partly consumed word, so the next transfer starts from byte 0 of a freshly pushed word.
- R12: cfg_addr 3 bits 4:0 set the transmit threshold and bits 12:8 set the receive threshold. tx_req is 1 while txq_level is at or below the transmit threshold. rx_req is 1 while rxq_level is at or above the receive threshold and the receive queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 length, 2 divider, 3 thresholds |
| cfg_wdata | input | 16 | Configuration write data |
| txq_push | input | 1 | Push one word into the transmit queue |
| txq_data | input | 32 | Word to push |
| txq_full | output | 1 | Transmit queue full |
| txq_level | output | 5 | Words held in the transmit queue |
| rxq_pop | input | 1 | Remove the head word of the receive queue |
| rxq_data | output | 32 | Head word of the receive queue |
| rxq_empty | output | 1 | Receive queue empty |
| rxq_full | output | 1 | Receive queue full |
| rxq_level | output | 5 | Words held in the receive queue |
| tx_req | output | 1 | Transmit refill request |
| rx_req | output | 1 | Receive drain request |
| xfer_active | output | 1 | Run flag |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ce_n | output | 2 | Active-low chip enables |

## Verification
The bench keeps the default 16-word queues and 16-bit count and divider. Those defaults put queue-level and threshold behaviour in reach with only a few words pushed. It programs divider values of 2 and 3, which keeps each serial bit to a handful of cycles so byte counts from 0 to 8 finish quickly. The small divider also lets the exact sclk period be measured. miso is looped back to mosi, so every received word can be predicted from the transmit word and the byte count. This covers partial words, leftover bytes, and both chip-enable framing modes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTES_PER_WORD = 4;
  localparam int WORD_W         = 8 * BYTES_PER_WORD;
  localparam int PTR_W          = $clog2(BYTES_PER_WORD);

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_HIGH,
    ENG_NEXT,
    ENG_GAP
  } eng_state_e;

  localparam int CTL_TXCLR = 2;
  localparam int CTL_RXCLR = 3;
  localparam int CTL_GO    = 4;
  localparam int CTL_AUTO  = 5;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [LW-1:0] cnt, cnt_n;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign level   = cnt;
  assign dout    = mem[rd_ptr];
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = cnt;
    if (clr) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (push_ok) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      cnt_n = cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spim_lanes.sv
module spim_lanes
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              take,
  output logic [7:0]        tx_byte,
  output logic              tx_pop,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [7:0]        rx_byte,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word
);
  logic [PTR_W-1:0]  tx_ptr, tx_ptr_n, rx_ptr, rx_ptr_n;
  logic [WORD_W-1:0] acc, acc_n;

  assign tx_byte = tx_word[8*tx_ptr +: 8];

  always_comb begin
    tx_ptr_n = tx_ptr;
    tx_pop   = 1'b0;
    if (tx_clr) begin
      tx_ptr_n = '0;
    end else if (take) begin
      if (tx_ptr == PTR_W'(BYTES_PER_WORD - 1)) begin
        tx_pop   = 1'b1;
        tx_ptr_n = '0;
      end else begin
        tx_ptr_n = tx_ptr + 1'b1;
      end
    end
  end

  always_comb begin
    rx_word               = acc;
    rx_word[8*rx_ptr +: 8] = rx_byte;
    acc_n                 = acc;
    rx_ptr_n              = rx_ptr;
    rx_push               = 1'b0;
    if (rx_clr) begin
      acc_n    = '0;
      rx_ptr_n = '0;
    end else if (rx_valid) begin
      if (rx_ptr == PTR_W'(BYTES_PER_WORD - 1) || rx_last) begin
        rx_push  = 1'b1;
        acc_n    = '0;
        rx_ptr_n = '0;
      end else begin
        acc_n    = rx_word;
        rx_ptr_n = rx_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ptr <= '0;
      rx_ptr <= '0;
      acc    <= '0;
    end else begin
      tx_ptr <= tx_ptr_n;
      rx_ptr <= rx_ptr_n;
      acc    <= acc_n;
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             len_zero,
  input  logic             auto_ce,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_avail,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             take,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic             sclk,
  output logic             mosi,
  output logic             grp_open
);
  eng_state_e       state, state_n;
  logic [DIV_W:0]   cnt, cnt_n, div_eff, lim;
  logic [2:0]       bitcnt, bitcnt_n;
  logic [7:0]       tx_sh, tx_sh_n, rx_sh, rx_sh_n;
  logic             sclk_n, grp_open_n, grp_half, grp_half_n;
  logic             timed, tick;

  assign div_eff = (div == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, div};
  assign lim     = div_eff - {{DIV_W{1'b0}}, 1'b1};
  assign timed   = (state == ENG_LEAD) || (state == ENG_HIGH) || (state == ENG_GAP);
  assign tick    = timed && (cnt == lim);
  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

  always_comb begin
    state_n    = state;
    cnt_n      = (timed && !tick) ? cnt + 1'b1 : '0;
    bitcnt_n   = bitcnt;
    tx_sh_n    = tx_sh;
    rx_sh_n    = rx_sh;
    sclk_n     = sclk;
    grp_open_n = grp_open;
    grp_half_n = grp_half;
    take       = 1'b0;
    byte_done  = 1'b0;
    case (state)
      ENG_IDLE: begin
        if (active && !len_zero && tx_avail) begin
          take       = 1'b1;
          tx_sh_n    = tx_byte;
          bitcnt_n   = '0;
          grp_open_n = 1'b1;
          grp_half_n = 1'b0;
          state_n    = ENG_LEAD;
        end
      end
      ENG_LEAD: begin
        if (tick) begin
          sclk_n  = 1'b1;
          rx_sh_n = {rx_sh[6:0], miso};
          state_n = ENG_HIGH;
        end
      end
      ENG_HIGH: begin
        if (tick) begin
          sclk_n = 1'b0;
          if (bitcnt == 3'd7) begin
            byte_done  = 1'b1;
            grp_half_n = ~grp_half;
            state_n    = ENG_NEXT;
          end else begin
            tx_sh_n  = {tx_sh[6:0], 1'b0};
            bitcnt_n = bitcnt + 1'b1;
            state_n  = ENG_LEAD;
          end
        end
      end
      ENG_NEXT: begin
        if (len_zero) begin
          grp_open_n = 1'b0;
          state_n    = ENG_IDLE;
        end else if (auto_ce && !grp_half) begin
          grp_open_n = 1'b0;
          state_n    = ENG_GAP;
        end else if (tx_avail) begin
          take     = 1'b1;
          tx_sh_n  = tx_byte;
          bitcnt_n = '0;
          state_n  = ENG_LEAD;
        end
      end
      ENG_GAP: begin
        if (tick) state_n = ENG_IDLE;
      end
      default: state_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      cnt      <= '0;
      bitcnt   <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk     <= 1'b0;
      grp_open <= 1'b0;
      grp_half <= 1'b0;
    end else begin
      state    <= state_n;
      cnt      <= cnt_n;
      bitcnt   <= bitcnt_n;
      tx_sh    <= tx_sh_n;
      rx_sh    <= rx_sh_n;
      sclk     <= sclk_n;
      grp_open <= grp_open_n;
      grp_half <= grp_half_n;
    end
  end
endmodule

// File: rtl/spi_len_master.sv
module spi_len_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 16,
  parameter int DIV_W      = 16,
  parameter int CFG_W      = 16,
  parameter int NUM_CE     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [CFG_W-1:0]            cfg_wdata,
  input  logic                        txq_push,
  input  logic [31:0]                 txq_data,
  output logic                        txq_full,
  output logic [$clog2(FIFO_DEPTH):0] txq_level,
  input  logic                        rxq_pop,
  output logic [31:0]                 rxq_data,
  output logic                        rxq_empty,
  output logic                        rxq_full,
  output logic [$clog2(FIFO_DEPTH):0] rxq_level,
  output logic                        tx_req,
  output logic                        rx_req,
  output logic                        xfer_active,
  output logic                        sclk,
  output logic                        mosi,
  input  logic                        miso,
  output logic [NUM_CE-1:0]           ce_n
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
  localparam int SEL_W = 2;
  localparam int RXT_LSB = 8;

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [SEL_W-1:0] ce_sel, ce_sel_n;
  logic             auto_ce, auto_ce_n, active, active_n;
  logic [LEN_W-1:0] len, len_n;
  logic [DIV_W-1:0] div, div_n;
  logic [LVL_W-1:0] tx_thr, tx_thr_n, rx_thr, rx_thr_n;
  logic             wr_ctl, wr_len, wr_div, wr_thr, tx_clr, rx_clr;
  logic             len_zero;

  logic [31:0] tx_head, rx_word;
  logic        tx_empty, tx_pop, rx_push;
  logic        take, byte_done, grp_open, ce_low;
  logic [7:0]  tx_byte, rx_byte;

  assign wr_ctl   = cfg_we && (cfg_addr == 2'd0);
  assign wr_len   = cfg_we && (cfg_addr == 2'd1);
  assign wr_div   = cfg_we && (cfg_addr == 2'd2);
  assign wr_thr   = cfg_we && (cfg_addr == 2'd3);
  assign tx_clr   = wr_ctl && cfg_wdata[CTL_TXCLR];
  assign rx_clr   = wr_ctl && cfg_wdata[CTL_RXCLR];
  assign len_zero = (len == '0);

  always_comb begin
    ce_sel_n  = ce_sel;
    auto_ce_n = auto_ce;
    active_n  = active;
    len_n     = len;
    div_n     = div;
    tx_thr_n  = tx_thr;
    rx_thr_n  = rx_thr;
    if (active) begin
      if (len_zero) active_n = 1'b0;
    end else if (wr_ctl) begin
      ce_sel_n  = cfg_wdata[SEL_W-1:0];
      auto_ce_n = cfg_wdata[CTL_AUTO];
      active_n  = cfg_wdata[CTL_GO];
    end
    if (wr_len && !active)          len_n = cfg_wdata[LEN_W-1:0];
    else if (byte_done && !len_zero) len_n = len - 1'b1;
    if (wr_div && !active) div_n = cfg_wdata[DIV_W-1:0];
    if (wr_thr) begin
      tx_thr_n = cfg_wdata[LVL_W-1:0];
      rx_thr_n = cfg_wdata[RXT_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ce_sel  <= '0;
      auto_ce <= 1'b0;
      active  <= 1'b0;
      len     <= '0;
      div     <= DIV_W'(2);
      tx_thr  <= LVL_W'(8);
      rx_thr  <= LVL_W'(8);
    end else begin
      ce_sel  <= ce_sel_n;
      auto_ce <= auto_ce_n;
      active  <= active_n;
      len     <= len_n;
      div     <= div_n;
      tx_thr  <= tx_thr_n;
      rx_thr  <= rx_thr_n;
    end
  end

  spim_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .clr(tx_clr),
    .push(txq_push), .din(txq_data), .pop(tx_pop), .dout(tx_head),
    .empty(tx_empty), .full(txq_full), .level(txq_level)
  );

  spim_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .clr(rx_clr),
    .push(rx_push), .din(rx_word), .pop(rxq_pop), .dout(rxq_data),
    .empty(rxq_empty), .full(rxq_full), .level(rxq_level)
  );

  spim_lanes u_lanes (
    .clk(clk), .rst_n(rst_i_n), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .tx_word(tx_head), .take(take), .tx_byte(tx_byte), .tx_pop(tx_pop),
    .rx_valid(byte_done), .rx_last(byte_done && (len == LEN_W'(1))),
    .rx_byte(rx_byte), .rx_push(rx_push), .rx_word(rx_word)
  );

  spim_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_i_n), .active(active), .len_zero(len_zero),
    .auto_ce(auto_ce), .div(div), .tx_avail(!tx_empty), .tx_byte(tx_byte),
    .miso(miso), .take(take), .byte_done(byte_done), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi), .grp_open(grp_open)
  );

  assign ce_low = auto_ce ? grp_open : active;

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    assign ce_n[g] = ~(ce_low && (ce_sel == SEL_W'(g)));
  end

  assign xfer_active = active;
  assign tx_req      = (txq_level <= tx_thr);
  assign rx_req      = !rxq_empty && (rxq_level >= rx_thr);
endmodule

// File: rtl/spi_len_master_chk.sv
module spi_len_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       mosi,
  input logic       xfer_active,
  input logic [1:0] ce_n,
  input logic       rxq_empty,
  input logic       rx_req
);
  assert_sclk_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> xfer_active);

  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);

  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> (&ce_n));

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_no_req_when_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_empty |-> !rx_req);

  assert_stop_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |-> !sclk);
endmodule

bind spi_len_master spi_len_master_chk chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
  .xfer_active(xfer_active), .ce_n(ce_n[1:0]),
  .rxq_empty(rxq_empty), .rx_req(rx_req)
);

// File: tb/spi_len_master_test.sv
module spi_len_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        txq_push = 1'b0;
  logic [31:0] txq_data = '0;
  logic        rxq_pop = 1'b0;
  logic        txq_full, rxq_empty, rxq_full, tx_req, rx_req, xfer_active;
  logic        sclk, mosi, miso;
  logic [4:0]  txq_level, rxq_level;
  logic [31:0] rxq_data;
  logic [1:0]  ce_n;

  int nchk = 0, nfail = 0;
  int cyc = 0, bits = 0, falls0 = 0, falls1 = 0, prev_rise = 0, last_rise = 0;
  logic [7:0] first_byte;
  logic sclk_q = 1'b0;
  logic [1:0] ce_q = 2'b11;

  localparam logic [15:0] TXC = 16'h0004, RXC = 16'h0008, GO = 16'h0010, AUTO = 16'h0020;

  assign miso = mosi;

  spi_len_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .txq_push(txq_push), .txq_data(txq_data),
    .txq_full(txq_full), .txq_level(txq_level), .rxq_pop(rxq_pop),
    .rxq_data(rxq_data), .rxq_empty(rxq_empty), .rxq_full(rxq_full),
    .rxq_level(rxq_level), .tx_req(tx_req), .rx_req(rx_req),
    .xfer_active(xfer_active), .sclk(sclk), .mosi(mosi), .miso(miso), .ce_n(ce_n)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sclk_q <= sclk;
    ce_q <= ce_n;
    if (sclk && !sclk_q) begin
      if (bits < 8) first_byte <= {first_byte[6:0], mosi};
      bits <= bits + 1;
      prev_rise <= last_rise;
      last_rise <= cyc;
    end
    if (ce_q[0] && !ce_n[0]) falls0 <= falls0 + 1;
    if (ce_q[1] && !ce_n[1]) falls1 <= falls1 + 1;
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    txq_push = 1'b1; txq_data = w;
    @(negedge clk);
    txq_push = 1'b0;
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk);
    w = rxq_empty ? 32'hDEAD_0000 : rxq_data;
    rxq_pop = 1'b1;
    @(negedge clk);
    rxq_pop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!xfer_active) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic zero_mon();
    @(negedge clk);
    bits = 0; falls0 = 0; falls1 = 0;
  endtask

  // {len, auto, tx word, expected rx word, expected ce_n[0] falls}
  localparam logic [87:0] VEC [5] = '{
    {8'd4, 8'd0, 32'h44332211, 32'h44332211, 8'd1},
    {8'd2, 8'd1, 32'hA5C30F81, 32'h00000F81, 8'd1},
    {8'd4, 8'd1, 32'h12345678, 32'h12345678, 8'd2},
    {8'd3, 8'd1, 32'hDEADBEEF, 32'h00ADBEEF, 8'd2},
    {8'd1, 8'd0, 32'h000000C6, 32'h000000C6, 8'd1}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check({31'd0, xfer_active}, 0, "R1 xfer_active");
    check({31'd0, sclk}, 0, "R1 sclk");
    check({30'd0, ce_n}, 3, "R1 ce_n");
    check({31'd0, rxq_empty}, 1, "R1 rxq_empty");
    check({27'd0, txq_level}, 0, "R1 txq_level");
    check({30'd0, tx_req, rx_req}, 2, "R1 tx_req/rx_req");

    wr(2'd2, 16'd2);

    // Vector table: R5 byte order, R7 packing, R8 framing, R3 count
    for (int i = 0; i < 5; i++) begin
      logic [87:0] v;
      logic [15:0] am;
      v  = VEC[i];
      am = v[79:72] != 0 ? AUTO : 16'h0;
      wr(2'd0, TXC | RXC | am);
      wr(2'd1, {8'd0, v[87:80]});
      push(v[71:40]);
      zero_mon();
      wr(2'd0, GO | am);
      wait_idle();
      check({31'd0, xfer_active}, 0, "R3 self-clear");
      check(bits, {21'd0, v[87:80], 3'd0}, "R3 bit count");
      check({24'd0, first_byte}, {24'd0, v[47:40]}, "R5 first byte");
      pop(w);
      check(w, v[39:8], "R7 rx word");
      check(falls0, {24'd0, v[7:0]}, "R8 ce framing");
    end

    // R6 leftover bytes
    wr(2'd0, TXC | RXC);
    wr(2'd1, 16'd2);
    push(32'hCCBBAA99);
    wr(2'd0, GO);
    wait_idle();
    pop(w);
    check(w, 32'h0000AA99, "R6 first half");
    check({27'd0, txq_level}, 1, "R6 word retained");
    wr(2'd1, 16'd2);
    wr(2'd0, GO);
    wait_idle();
    pop(w);
    check(w, 32'h0000CCBB, "R6 leftover used");
    check({27'd0, txq_level}, 0, "R6 word consumed");

    // R2 stall without data, R4 writes ignored while active
    wr(2'd0, TXC | RXC);
    wr(2'd1, 16'd2);
    zero_mon();
    wr(2'd0, GO);
    repeat (40) @(negedge clk);
    check({31'd0, xfer_active}, 1, "R2 waits active");
    check(bits, 0, "R2 no clock without data");
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd9);
    wr(2'd0, GO | AUTO | 16'd1);
    push(32'h00007755);
    wait_idle();
    check(bits, 16, "R4 length write ignored");
    check(last_rise - prev_rise, 4, "R4 divider write ignored");
    check(falls0, 1, "R4 select/auto write ignored");
    pop(w);
    check(w, 32'h00007755, "R2 resumes on data");

    // R3 zero length
    wr(2'd1, 16'd0);
    zero_mon();
    wr(2'd0, GO);
    repeat (10) @(negedge clk);
    check({31'd0, xfer_active}, 0, "R3 zero length clears");
    check(bits, 0, "R3 zero length no clock");

    // R9 select field
    wr(2'd0, TXC | RXC | 16'd1);
    wr(2'd1, 16'd1);
    push(32'h0000003C);
    zero_mon();
    wr(2'd0, GO | 16'd1);
    wait_idle();
    check(falls1, 1, "R9 sel1 drives ce_n[1]");
    check(falls0, 0, "R9 sel1 leaves ce_n[0]");
    wr(2'd0, TXC | RXC | 16'd2);
    wr(2'd1, 16'd1);
    push(32'h0000003C);
    zero_mon();
    wr(2'd0, GO | 16'd2);
    wait_idle();
    check(falls0 + falls1, 0, "R9 sel2 drives none");
    check(bits, 8, "R9 sel2 still shifts");

    // R10 divider
    wr(2'd2, 16'd3);
    wr(2'd0, TXC | RXC);
    wr(2'd1, 16'd1);
    push(32'h000000E1);
    wr(2'd0, GO);
    wait_idle();
    check(last_rise - prev_rise, 6, "R10 sclk period div3");
    wr(2'd2, 16'd2);

    // R11 clears
    wr(2'd0, TXC | RXC);
    push(32'h1); push(32'h2); push(32'h3);
    check({27'd0, txq_level}, 3, "R11 level before clear");
    wr(2'd0, TXC);
    check({27'd0, txq_level}, 0, "R11 tx clear empties");
    push(32'h44434241);
    wr(2'd1, 16'd1);
    wr(2'd0, GO);
    wait_idle();
    wr(2'd0, TXC | RXC);
    check({31'd0, rxq_empty}, 1, "R11 rx clear empties");
    push(32'h5A5A5AB7);
    wr(2'd1, 16'd1);
    wr(2'd0, GO);
    wait_idle();
    pop(w);
    check(w, 32'h000000B7, "R11 pointer reset");

    // R12 thresholds
    wr(2'd3, 16'h0201);
    wr(2'd0, TXC | RXC);
    @(negedge clk);
    check({31'd0, tx_req}, 1, "R12 tx_req empty");
    push(32'h87654321); push(32'h0FEDCBA9);
    @(negedge clk);
    check({31'd0, tx_req}, 0, "R12 tx_req above thr");
    wr(2'd1, 16'd8);
    wr(2'd0, GO);
    wait_idle();
    check({31'd0, rx_req}, 1, "R12 rx_req at thr");
    pop(w);
    check(w, 32'h87654321, "R7 full word 1");
    check({31'd0, rx_req}, 0, "R12 rx_req below thr");
    pop(w);
    check(w, 32'h0FEDCBA9, "R7 full word 2");
    check({31'd0, tx_req}, 1, "R12 tx_req drained");

    finish_run();
  end
endmodule